// File: doc/BRIEF.md
# Processor Status Flag Register

This block is the status register of a small 8-bit CPU core. It stores six flags: negative (N), overflow (V), decimal (D), interrupt mask (I), zero (Z) and carry (C). Each flag can be changed from several sources. These are a result or load path, a memory bit-test path, explicit set and clear commands, a full restore from a byte pulled off the stack, and an external active-low pin that forces overflow. All strobes last one cycle. The register changes on the rising clock edge and resets synchronously.

The block does not store the break bit or the fixed bit. Both are produced only when the status byte is read out. The push byte carries a break bit that depends on the kind of push: it is 0 only for a push made on entry to a hardware interrupt.

The instruction decoder drives the strobes. A stack-pointer transfer simply does not raise `upd_stb`, so N and Z stay as they are.

Top module: `status_flag_reg`

## Requirements
- R1: The readout and push bytes place N, V, fixed, break, D, I, Z, C at bits 7 down to 0. Bit 5 is always 1. The readout `status_out` also shows bit 4 as 1.
- R2: `push_byte` bit 4 is 0 when `push_hw` is 1 and 1 when `push_hw` is 0. All other bits of `push_byte` equal `status_out`.
- R3: `upd_stb` sets N to bit 7 of `upd_value`. It sets Z to 1 exactly when `upd_value` is zero. In the same cycle, C takes `upd_c` when `upd_c_en` is 1, and V takes `upd_v` when `upd_v_en` is 1.
- R4: `bit_stb` copies operand bit 7 to N and operand bit 6 to V. It sets Z to 1 exactly when `bit_operand & bit_acc` is zero. C is left unchanged.
- R5: `flag_cmd` codes: 0 none, 1 set C, 2 clear C, 3 set I, 4 clear I, 5 set D, 6 clear D, 7 clear V. There is no code that sets V.
- R6: `restore_stb` loads N, V, D, I, Z, C from bits 7, 6, 3, 2, 1, 0 of `restore_byte`.
- R7: A falling edge on `so_n` sets V. The edge first passes a two-stage synchronizer, so V reads 1 after the third rising edge after the fall. Holding `so_n` low does not set V again.
- R8: A synchronized `so_n` fall sets V even if a clear-V command or a restore arrives in the same cycle.
- R9: When several sources are strobed together, each flag takes its value from the highest-priority source: restore first, then `flag_cmd`, then `bit_stb`, then `upd_stb`.
- R10: After reset, I is 1 and N, V, D, Z, C are 0, so `status_out` reads 8'h34.
- R11: In a cycle with no strobe, no command and no synchronized `so_n` fall, every flag keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_stb | input | 1 | Result/load update strobe |
| upd_value | input | 8 | Value loaded; drives N and Z |
| upd_c_en | input | 1 | Apply `upd_c` to C |
| upd_c | input | 1 | New carry |
| upd_v_en | input | 1 | Apply `upd_v` to V |
| upd_v | input | 1 | New overflow |
| bit_stb | input | 1 | Memory bit-test strobe |
| bit_operand | input | 8 | Memory operand of the bit test |
| bit_acc | input | 8 | Accumulator for the Z test |
| flag_cmd | input | 3 | Set/clear command code |
| restore_stb | input | 1 | Restore from pulled byte |
| restore_byte | input | 8 | Byte pulled from the stack |
| so_n | input | 1 | Asynchronous active-low set-overflow pin |
| push_hw | input | 1 | Push is a hardware-interrupt entry |
| push_byte | output | 8 | Status byte to push |
| status_out | output | 8 | Status readout |

## Verification
The properties assume the strobes and `flag_cmd` are clean, defined values that are held through each rising edge. They also assume `so_n` is high while reset is active, so that reset release does not look like a falling edge. The bench changes every input only on the falling clock edge. It keeps `so_n` high through reset, and before each new fall it raises `so_n` for several cycles so the synchronizer sees a clean edge. The overflow-override cases are timed so that the command lands in the one cycle in which the synchronized fall is present.

// File: rtl/status_reg_pkg.sv
package status_reg_pkg;

    localparam int BYTE_W = 8;

    // bit positions of the status byte; the stack image relies on this order
    localparam int POS_N   = 7;
    localparam int POS_V   = 6;
    localparam int POS_ONE = 5;
    localparam int POS_BRK = 4;
    localparam int POS_D   = 3;
    localparam int POS_I   = 2;
    localparam int POS_Z   = 1;
    localparam int POS_C   = 0;

    typedef enum logic [2:0] {
        FC_NONE  = 3'd0,
        FC_SET_C = 3'd1,
        FC_CLR_C = 3'd2,
        FC_SET_I = 3'd3,
        FC_CLR_I = 3'd4,
        FC_SET_D = 3'd5,
        FC_CLR_D = 3'd6,
        FC_CLR_V = 3'd7
    } flag_cmd_e;

    typedef struct packed {
        logic n;
        logic v;
        logic d;
        logic i;
        logic z;
        logic c;
    } flags_t;

    localparam flags_t FLAGS_RESET = '{n: 1'b0, v: 1'b0, d: 1'b0,
                                       i: 1'b1, z: 1'b0, c: 1'b0};

    function automatic logic [BYTE_W-1:0] pack_status(flags_t f, logic brk);
        logic [BYTE_W-1:0] b;
        b          = '0;
        b[POS_N]   = f.n;
        b[POS_V]   = f.v;
        b[POS_ONE] = 1'b1;
        b[POS_BRK] = brk;
        b[POS_D]   = f.d;
        b[POS_I]   = f.i;
        b[POS_Z]   = f.z;
        b[POS_C]   = f.c;
        return b;
    endfunction

    function automatic flags_t unpack_status(logic [BYTE_W-1:0] b);
        flags_t f;
        f.n = b[POS_N];
        f.v = b[POS_V];
        f.d = b[POS_D];
        f.i = b[POS_I];
        f.z = b[POS_Z];
        f.c = b[POS_C];
        return f;
    endfunction

endpackage

// File: rtl/so_edge_sync.sv
module so_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic fall
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= pin_n;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= {sync_q[STAGES-2:0], pin_n};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= sync_q[LAST];
    end

    assign fall = prev_q & ~sync_q[LAST];
endmodule

// File: rtl/flag_next.sv
module flag_next
    import status_reg_pkg::*;
(
    input  flags_t              cur,
    input  logic                upd_stb,
    input  logic [BYTE_W-1:0]   upd_value,
    input  logic                upd_c_en,
    input  logic                upd_c,
    input  logic                upd_v_en,
    input  logic                upd_v,
    input  logic                bit_stb,
    input  logic [BYTE_W-1:0]   bit_operand,
    input  logic [BYTE_W-1:0]   bit_acc,
    input  flag_cmd_e           cmd,
    input  logic                restore_stb,
    input  flags_t              restored,
    input  logic                so_fall,
    output flags_t              nxt
);
    always_comb begin
        nxt = cur;

        // lowest priority: result/load path
        if (upd_stb) begin
            nxt.n = upd_value[BYTE_W-1];
            nxt.z = (upd_value == '0);
            if (upd_c_en) nxt.c = upd_c;
            if (upd_v_en) nxt.v = upd_v;
        end

        // memory bit test overrides the load path
        if (bit_stb) begin
            nxt.n = bit_operand[BYTE_W-1];
            nxt.v = bit_operand[BYTE_W-2];
            nxt.z = ((bit_operand & bit_acc) == '0);
        end

        // explicit commands
        unique case (cmd)
            FC_SET_C: nxt.c = 1'b1;
            FC_CLR_C: nxt.c = 1'b0;
            FC_SET_I: nxt.i = 1'b1;
            FC_CLR_I: nxt.i = 1'b0;
            FC_SET_D: nxt.d = 1'b1;
            FC_CLR_D: nxt.d = 1'b0;
            FC_CLR_V: nxt.v = 1'b0;
            default:  ;
        endcase

        // full restore beats every other source
        if (restore_stb) nxt = restored;

        // external overflow set wins on V
        if (so_fall) nxt.v = 1'b1;
    end
endmodule

// File: rtl/status_pack.sv
module status_pack
    import status_reg_pkg::*;
(
    input  flags_t              flags,
    input  logic                push_hw,
    output logic [BYTE_W-1:0]   push_byte,
    output logic [BYTE_W-1:0]   readout
);
    assign push_byte = pack_status(flags, ~push_hw);
    assign readout   = pack_status(flags, 1'b1);
endmodule

// File: rtl/status_flag_reg.sv
module status_flag_reg
    import status_reg_pkg::*;
#(
    parameter int SO_SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       upd_stb,
    input  logic [7:0] upd_value,
    input  logic       upd_c_en,
    input  logic       upd_c,
    input  logic       upd_v_en,
    input  logic       upd_v,
    input  logic       bit_stb,
    input  logic [7:0] bit_operand,
    input  logic [7:0] bit_acc,
    input  logic [2:0] flag_cmd,
    input  logic       restore_stb,
    input  logic [7:0] restore_byte,
    input  logic       so_n,
    input  logic       push_hw,
    output logic [7:0] push_byte,
    output logic [7:0] status_out
);
    flags_t flags_q;
    flags_t flags_d;
    flags_t restored;
    logic   so_fall;

    assign restored = unpack_status(restore_byte);

    so_edge_sync #(.STAGES(SO_SYNC_STAGES)) u_so (
        .clk   (clk),
        .rst   (rst),
        .pin_n (so_n),
        .fall  (so_fall)
    );

    flag_next u_next (
        .cur         (flags_q),
        .upd_stb     (upd_stb),
        .upd_value   (upd_value),
        .upd_c_en    (upd_c_en),
        .upd_c       (upd_c),
        .upd_v_en    (upd_v_en),
        .upd_v       (upd_v),
        .bit_stb     (bit_stb),
        .bit_operand (bit_operand),
        .bit_acc     (bit_acc),
        .cmd         (flag_cmd_e'(flag_cmd)),
        .restore_stb (restore_stb),
        .restored    (restored),
        .so_fall     (so_fall),
        .nxt         (flags_d)
    );

    always_ff @(posedge clk) begin
        if (rst) flags_q <= FLAGS_RESET;
        else     flags_q <= flags_d;
    end

    status_pack u_pack (
        .flags     (flags_q),
        .push_hw   (push_hw),
        .push_byte (push_byte),
        .readout   (status_out)
    );
endmodule

// File: rtl/status_flag_chk.sv
module status_flag_chk (
    input logic       clk,
    input logic       rst,
    input logic       upd_stb,
    input logic [7:0] upd_value,
    input logic       bit_stb,
    input logic [2:0] flag_cmd,
    input logic       restore_stb,
    input logic [7:0] restore_byte,
    input logic       so_fall,
    input logic       push_hw,
    input logic [7:0] push_byte,
    input logic [7:0] status_out
);
    a_r1_fixed_bit: assert property (@(posedge clk) disable iff (rst)
        status_out[5] && push_byte[5]);

    a_r2_break_bit: assert property (@(posedge clk) disable iff (rst)
        (push_byte[4] == !push_hw) && (push_byte[7:5] == status_out[7:5])
        && (push_byte[3:0] == status_out[3:0]));

    a_r3_load_nz: assert property (@(posedge clk) disable iff (rst)
        (upd_stb && !bit_stb && !restore_stb) |=>
        (status_out[7] == $past(upd_value[7])) &&
        (status_out[1] == ($past(upd_value) == 8'h00)));

    a_r5_clear_v: assert property (@(posedge clk) disable iff (rst)
        (flag_cmd == 3'd7 && !restore_stb && !so_fall) |=> !status_out[6]);

    a_r6_restore: assert property (@(posedge clk) disable iff (rst)
        (restore_stb && !so_fall) |=>
        (status_out[7:6] == $past(restore_byte[7:6])) &&
        (status_out[3:0] == $past(restore_byte[3:0])));

    a_r8_so_wins: assert property (@(posedge clk) disable iff (rst)
        so_fall |=> status_out[6]);

    a_r10_reset_value: assert property (@(posedge clk)
        rst |=> (status_out == 8'h34));

    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (!upd_stb && !bit_stb && !restore_stb && flag_cmd == 3'd0 && !so_fall)
        |=> $stable(status_out));
endmodule

bind status_flag_reg status_flag_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .upd_stb      (upd_stb),
    .upd_value    (upd_value),
    .bit_stb      (bit_stb),
    .flag_cmd     (flag_cmd),
    .restore_stb  (restore_stb),
    .restore_byte (restore_byte),
    .so_fall      (so_fall),
    .push_hw      (push_hw),
    .push_byte    (push_byte),
    .status_out   (status_out)
);

// File: tb/tb_status_flag_reg.sv
module tb_status_flag_reg;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 5000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       upd_stb = 1'b0;
    logic [7:0] upd_value = '0;
    logic       upd_c_en = 1'b0, upd_c = 1'b0, upd_v_en = 1'b0, upd_v = 1'b0;
    logic       bit_stb = 1'b0;
    logic [7:0] bit_operand = '0, bit_acc = '0;
    logic [2:0] flag_cmd = '0;
    logic       restore_stb = 1'b0;
    logic [7:0] restore_byte = '0;
    logic       so_n = 1'b1;
    logic       push_hw = 1'b0;
    logic [7:0] push_byte, status_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    status_flag_reg dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic       us;
        logic [7:0] uv;
        logic       ce, c, ve, v;
        logic       bs;
        logic [7:0] op, acc;
        logic [2:0] cmd;
        logic       rs;
        logic [7:0] rb;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    // rows run in order from the reset value 8'h34
    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h80, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 3'd0, 1'b0, 8'h00, 8'hF5, 4'd3}, // R3
        '{1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 3'd0, 1'b0, 8'h00, 8'h77, 4'd3}, // R3
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 3'd7, 1'b0, 8'h00, 8'h37, 4'd5}, // R5
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 3'd2, 1'b0, 8'h00, 8'h36, 4'd5}, // R5
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 3'd4, 1'b0, 8'h00, 8'h32, 4'd5}, // R5
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 3'd5, 1'b0, 8'h00, 8'h3A, 4'd5}, // R5
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hC0, 8'h3F, 3'd0, 1'b0, 8'h00, 8'hFA, 4'd4}, // R4
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h01, 8'h01, 3'd0, 1'b0, 8'h00, 8'h38, 4'd4}, // R4
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 3'd0, 1'b1, 8'hC3, 8'hF3, 4'd6}, // R6
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 3'd0, 1'b1, 8'h00, 8'h30, 4'd6}, // R6
        '{1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 3'd2, 1'b1, 8'hFF, 8'hFF, 4'd9}, // R9
        '{1'b1, 8'h01, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 3'd2, 1'b0, 8'h00, 8'h7C, 4'd9}, // R9
        '{1'b1, 8'h80, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'hFF, 3'd0, 1'b0, 8'h00, 8'h3E, 4'd9}, // R9
        '{1'b1, 8'h40, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 3'd7, 1'b0, 8'h00, 8'h3C, 4'd9}, // R9
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 3'd0, 1'b0, 8'h00, 8'h3C, 4'd11}, // R11
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 3'd1, 1'b0, 8'h00, 8'h3D, 4'd5}, // R5
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 3'd6, 1'b0, 8'h00, 8'h35, 4'd5}, // R5
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 3'd0, 1'b0, 8'h00, 8'h35, 4'd11}  // R11
    };

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        upd_stb = 1'b0; upd_c_en = 1'b0; upd_v_en = 1'b0;
        bit_stb = 1'b0; flag_cmd = 3'd0; restore_stb = 1'b0;
    endtask

    // advance one rising edge and land on the following falling edge
    task automatic tick();
        @(negedge clk);
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // reset for three edges, so_n kept high
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state, R2 break bit, R1 fixed bit
        check("R10", status_out, 8'h34);
        check("R1", {7'd0, status_out[5]}, 8'h01);
        push_hw = 1'b0; #1;
        check("R2", push_byte, 8'h34);
        push_hw = 1'b1; #1;
        check("R2", push_byte, 8'h24);
        push_hw = 1'b0;

        foreach (VECS[k]) begin
            upd_stb = VECS[k].us; upd_value = VECS[k].uv;
            upd_c_en = VECS[k].ce; upd_c = VECS[k].c;
            upd_v_en = VECS[k].ve; upd_v = VECS[k].v;
            bit_stb = VECS[k].bs; bit_operand = VECS[k].op; bit_acc = VECS[k].acc;
            flag_cmd = VECS[k].cmd;
            restore_stb = VECS[k].rs; restore_byte = VECS[k].rb;
            tick();
            idle_inputs();
            check($sformatf("R%0d row %0d", VECS[k].req, k), status_out, VECS[k].exp);
        end

        // R2 push byte with a non-reset state (8'h35)
        push_hw = 1'b1; #1;
        check("R2 hw push", push_byte, 8'h25);
        push_hw = 1'b0; #1;
        check("R2 sw push", push_byte, 8'h35);
        check("R1 readout", {7'd0, status_out[5]}, 8'h01);

        // R7 so_n fall: V appears after the third edge only
        so_n = 1'b0;
        tick(); tick();
        check("R7 not yet", status_out, 8'h35);
        tick();
        check("R7 set", status_out, 8'h75);
        // held low: clear V, then stays clear
        flag_cmd = 3'd7;
        tick();
        idle_inputs();
        check("R7 clv while low", status_out, 8'h35);
        repeat (4) tick();
        check("R7 no retrigger", status_out, 8'h35);

        // R8 set beats a same-cycle clear-V
        so_n = 1'b1;
        repeat (4) tick();
        so_n = 1'b0;
        tick(); tick();
        flag_cmd = 3'd7;
        tick();
        idle_inputs();
        check("R8 vs clear", status_out, 8'h75);

        // R8 set beats a same-cycle restore of V=0
        so_n = 1'b1;
        repeat (4) tick();
        so_n = 1'b0;
        tick(); tick();
        restore_stb = 1'b1; restore_byte = 8'h01;
        tick();
        idle_inputs();
        check("R8 vs restore", status_out, 8'h71);
        so_n = 1'b1;
        repeat (4) tick();
        check("R11 quiet", status_out, 8'h71);

        // R10 reset in the middle of a run
        rst = 1'b1;
        tick();
        rst = 1'b0;
        check("R10 rerun", status_out, 8'h34);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule